// File: doc/BRIEF.md
# Burst Address Sequencer for a Pipelined Synchronous SRAM

This block captures an external word address when a burst starts and then steps through the remaining addresses of a four-beat burst. A burst can start in two ways. The processor strobe has priority, but the master chip enable gates it. The controller strobe counts only when the processor strobe is idle, and the master chip enable does not gate it. After a start, an active-low advance input moves the burst to its next beat, but only on edges where both strobes are idle.

The two low address bits form the burst offset and wrap within a group of four. The upper bits stay fixed for the whole burst. An order-select input chooses the sequence. High selects interleaved order: the offset is the start offset XOR the beat count. Low selects linear order: the offset is the start offset plus the beat count, modulo four.

A two-state machine tracks whether a burst is open. ST_IDLE moves to ST_ACTIVE on a start (T_START). ST_ACTIVE stays in ST_ACTIVE on a new start, an advance or a hold (T_RESTART, T_STEP, T_HOLD). Either state moves to ST_IDLE on a deselect (T_DESELECT). A deselect is a start attempt made while the secondary enables are inactive.

Top module: `burst_seq_top`

## Requirements
- R1: While reset (rst_n low) is asserted, valid is 0, addr_out is 0 and from_proc is 0.
- R2: On an edge where proc_stb_n=0, ce_main_n=0, ce_hi=1 and ce_lo_n=0, the block loads addr_in. The next cycle shows addr_out=addr_in, valid=1 and from_proc=1, whatever ctrl_stb_n holds.
- R3: On the edge that starts a burst, adv_n has no effect: the first beat is always the loaded address.
- R4: The beat advances only on an edge where adv_n=0, proc_stb_n=1, ctrl_stb_n=1 and valid=1. In every other case without a start or deselect, addr_out and valid hold.
- R5: With order_sel=1 at the start edge, beat k (k=0..3) shows addr_out[1:0] = start[1:0] XOR k.
- R6: With order_sel=0 at the start edge, beat k shows addr_out[1:0] = (start[1:0]+k) mod 4. addr_out[17:2] never changes during a burst.
- R7: When proc_stb_n=0 and ce_main_n=1, the processor start is blocked. addr_out, valid and from_proc hold, and no advance happens.
- R8: On an edge where proc_stb_n=1, ctrl_stb_n=0, ce_hi=1 and ce_lo_n=0, the block loads addr_in whatever ce_main_n holds. The next cycle shows valid=1 and from_proc=0.
- R9: A controller strobe has no effect while proc_stb_n=0, even when the processor start is blocked.
- R10: A start attempt (processor-qualified or controller) made with ce_hi=0 or ce_lo_n=1 clears valid and leaves addr_out unchanged.
- R11: order_sel is sampled only on a start edge. Changes during a burst do not alter its sequence.
- R12: After the fourth advance, the offset wraps back to the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_main_n | input | 1 | Master chip enable, active low, gates the processor strobe only |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| order_sel | input | 1 | 1 = interleaved, 0 = linear burst order |
| addr_in | input | 18 | External word address |
| addr_out | output | 18 | Current burst word address |
| valid | output | 1 | A burst is open |
| from_proc | output | 1 | 1 when the open burst was started by the processor strobe |

## Verification
The assertions assume that every input is a clean 0 or 1 at each sampling edge. They also assume that addr_in only matters on start edges, so that past-value comparisons refer to a defined address. The bench changes inputs only at falling edges, away from the sampling edge. It mixes directed sequences for each strobe, enable and order combination with a stretch of unconstrained random levels on all control pins. A behavioural model follows the random stretch every cycle, so contention between strobes, blocked starts and deselects are reached in arbitrary orders.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_ACTIVE
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_HOLD,
        CMD_LOAD,
        CMD_STEP,
        CMD_DESEL
    } seq_cmd_e;
endpackage

// File: rtl/burst_strobe_decode.sv
module burst_strobe_decode
    import burst_seq_pkg::*;
(
    input  logic     proc_stb_n,
    input  logic     ctrl_stb_n,
    input  logic     adv_n,
    input  logic     ce_main_n,
    input  logic     ce_hi,
    input  logic     ce_lo_n,
    input  logic     open_burst,
    output seq_cmd_e cmd,
    output logic     by_proc
);
    logic sec_en;
    logic proc_hit;
    logic ctrl_hit;

    always_comb begin
        sec_en   = ce_hi && !ce_lo_n;
        proc_hit = !proc_stb_n && !ce_main_n;
        ctrl_hit = proc_stb_n && !ctrl_stb_n;
        by_proc  = proc_hit;
        if (proc_hit || ctrl_hit) begin
            cmd = sec_en ? CMD_LOAD : CMD_DESEL;
        end else if (proc_stb_n && ctrl_stb_n && !adv_n && open_burst) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end
endmodule

// File: rtl/burst_addr_track.sv
module burst_addr_track
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_cmd_e          cmd,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - BURST_W;

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] beat_q;
    logic               ilv_q;
    logic [BURST_W-1:0] ofs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            ilv_q  <= 1'b1;
        end else begin
            unique case (cmd)
                CMD_LOAD: begin
                    base_q <= addr_in;
                    beat_q <= '0;
                    ilv_q  <= order_sel;
                end
                CMD_STEP: beat_q <= beat_q + 1'b1;
                default:  ;
            endcase
        end
    end

    generate
        if (BURST_W > 0) begin : g_ofs
            always_comb begin
                if (ilv_q) ofs = base_q[BURST_W-1:0] ^ beat_q;
                else       ofs = base_q[BURST_W-1:0] + beat_q;
            end
        end
    endgenerate

    assign addr_out = {base_q[ADDR_W-1 -: HI_W], ofs};
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_stb_n,
    input  logic              ctrl_stb_n,
    input  logic              adv_n,
    input  logic              ce_main_n,
    input  logic              ce_hi,
    input  logic              ce_lo_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              valid,
    output logic              from_proc
);
    seq_state_e state_q;
    seq_state_e state_d;
    seq_cmd_e   cmd;
    logic       by_proc;
    logic       src_q;

    burst_strobe_decode u_dec (
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .adv_n      (adv_n),
        .ce_main_n  (ce_main_n),
        .ce_hi      (ce_hi),
        .ce_lo_n    (ce_lo_n),
        .open_burst (state_q == ST_ACTIVE),
        .cmd        (cmd),
        .by_proc    (by_proc)
    );

    burst_addr_track #(
        .ADDR_W  (ADDR_W),
        .BURST_W (BURST_W)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .addr_out  (addr_out)
    );

    // Next-state selection: T_START, T_RESTART, T_STEP, T_HOLD, T_DESELECT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd == CMD_LOAD)  state_d = ST_ACTIVE;
            ST_ACTIVE: if (cmd == CMD_DESEL) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               src_q <= 1'b0;
        else if (cmd == CMD_LOAD) src_q <= by_proc;
    end

    always_comb begin
        valid     = (state_q == ST_ACTIVE);
        from_proc = src_q;
    end
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              proc_stb_n,
    input logic              ctrl_stb_n,
    input logic              adv_n,
    input logic              ce_main_n,
    input logic              ce_hi,
    input logic              ce_lo_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              valid,
    input logic              from_proc
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (!valid && !from_proc && addr_out == '0);
        end
    end

    a_r2_proc_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_stb_n && !ce_main_n && ce_hi && !ce_lo_n)
        |=> (valid && from_proc && addr_out == $past(addr_in)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_stb_n && ctrl_stb_n && adv_n)
        |=> ($stable(addr_out) && $stable(valid)));

    a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && proc_stb_n && ctrl_stb_n && !adv_n)
        |=> (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));

    a_r7_master_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_stb_n && ce_main_n)
        |=> ($stable(addr_out) && $stable(valid) && $stable(from_proc)));

    a_r8_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_stb_n && !ctrl_stb_n && ce_hi && !ce_lo_n)
        |=> (valid && !from_proc && addr_out == $past(addr_in)));

    a_r10_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (((!proc_stb_n && !ce_main_n) || (proc_stb_n && !ctrl_stb_n)) && !(ce_hi && !ce_lo_n))
        |=> (!valid && $stable(addr_out)));
endmodule

bind burst_seq_top burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .adv_n      (adv_n),
    .ce_main_n  (ce_main_n),
    .ce_hi      (ce_hi),
    .ce_lo_n    (ce_lo_n),
    .addr_in    (addr_in),
    .addr_out   (addr_out),
    .valid      (valid),
    .from_proc  (from_proc)
);

// File: tb/sim_burst_seq_top.sv
`timescale 1ns/1ps
module sim_burst_seq_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        p_n, c_n, a_n, m_n, h, l_n, o;
    logic [17:0] ain;
    logic [17:0] aout;
    logic        vld, fp;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // model state
    int  m_valid = 0;
    int  m_base  = 0;
    int  m_beat  = 0;
    int  m_ilv   = 1;
    int  m_proc  = 0;

    always #2.5 clk = ~clk;

    burst_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .proc_stb_n(p_n), .ctrl_stb_n(c_n),
        .adv_n(a_n), .ce_main_n(m_n), .ce_hi(h), .ce_lo_n(l_n),
        .order_sel(o), .addr_in(ain), .addr_out(aout), .valid(vld),
        .from_proc(fp)
    );

    function automatic int exp_addr();
        int lo;
        int ofs;
        lo  = m_base % 4;
        ofs = m_ilv ? (lo ^ m_beat) : ((lo + m_beat) % 4);
        return (m_base / 4) * 4 + ofs;
    endfunction

    task automatic drive(input logic p, input logic c, input logic a,
                         input logic m, input logic hh, input logic ll,
                         input logic oo, input int ad);
        p_n = p; c_n = c; a_n = a; m_n = m; h = hh; l_n = ll; o = oo;
        ain = ad[17:0];
    endtask

    task automatic compare(input string tag);
        checks++;
        if (int'(aout) != exp_addr() || int'(vld) != m_valid || int'(fp) != m_proc) begin
            fails++;
            $display("FAIL %s: addr=%h valid=%0d proc=%0d, expected addr=%h valid=%0d proc=%0d",
                     tag, aout, vld, fp, exp_addr(), m_valid, m_proc);
        end
    endtask

    task automatic step(input string tag);
        bit sec;
        @(posedge clk);
        sec = h && !l_n;
        if (!p_n && !m_n) begin
            if (sec) begin m_valid = 1; m_base = int'(ain); m_beat = 0; m_ilv = int'(o); m_proc = 1; end
            else m_valid = 0;
        end else if (p_n && !c_n) begin
            if (sec) begin m_valid = 1; m_base = int'(ain); m_beat = 0; m_ilv = int'(o); m_proc = 0; end
            else m_valid = 0;
        end else if (p_n && c_n && !a_n && m_valid == 1) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                fails++;
                $display("FAIL watchdog: cycles=%0d, expected below 20000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1, 1, 1, 1, 0, 1, 1, 0);
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;

        // R2/R3: processor start with controller strobe low and advance low
        drive(0, 0, 0, 0, 1, 0, 1, 18'h2A5B6);
        step("R2 R3 proc start");
        // R5 interleaved beats, R12 wrap
        drive(1, 1, 0, 0, 1, 0, 1, 0);
        step("R5 beat1");
        step("R5 beat2");
        step("R5 beat3");
        step("R12 wrap");
        // R4 hold with advance high
        drive(1, 1, 1, 0, 1, 0, 1, 0);
        step("R4 hold");
        // R7 blocked processor start with advance low
        drive(0, 1, 0, 1, 1, 0, 1, 18'h00007);
        step("R7 blocked");
        // R9 controller ignored while processor strobe low
        drive(0, 0, 1, 1, 1, 0, 0, 18'h11111);
        step("R9 ctrl vs proc");

        // R6 linear, R11 order change mid-burst
        drive(0, 1, 1, 0, 1, 0, 0, 18'h3C0F3);
        step("R6 linear start");
        drive(1, 1, 0, 0, 1, 0, 1, 0);
        step("R11 order toggled beat1");
        drive(1, 1, 0, 0, 1, 0, 0, 0);
        step("R6 beat2");
        step("R6 beat3");
        step("R12 linear wrap");

        // R8 controller start with master enable inactive
        drive(1, 0, 0, 1, 1, 0, 1, 18'h00005);
        step("R8 ctrl start");
        drive(1, 1, 0, 1, 1, 0, 1, 0);
        step("R8 ctrl beat1");

        // R10 deselect, then advance has no effect
        drive(0, 1, 1, 0, 0, 0, 1, 18'h12345);
        step("R10 deselect");
        drive(1, 1, 0, 0, 1, 0, 1, 0);
        step("R4 no advance idle");
        drive(1, 0, 1, 1, 1, 1, 1, 18'h00AAA);
        step("R10 ctrl deselect");

        // mixed stimulus
        for (int i = 0; i < 400; i++) begin
            drive(($urandom % 3) != 0, ($urandom % 3) != 0, $urandom % 2,
                  ($urandom % 4) == 0, ($urandom % 5) != 0, ($urandom % 5) == 0,
                  $urandom % 2, int'($urandom % 262144));
            step("R2 R4 R8 R10 mix");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule